// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Trap

This unit performs a 32-bit addition or subtraction on operands whose two low bits carry a type tag. An operation is legal only when both tags are zero and the signed result fits in 32 bits. A legal operation returns its result and commits four condition flags: negative, zero, overflow and carry. An illegal operation raises a one-cycle tag-overflow trap request, and the flags and result register keep their previous values.

One operation enters per cycle on a valid strobe. The unit applies no back-pressure: there is no ready signal, and every cycle with `op_valid` high is accepted. Each accepted operation gives exactly one response on the next clock edge. That response is either a `res_valid` pulse or a `trap_tag` pulse, never both. The consumer cannot stall the output, so it must take the response in the cycle it appears. The flags remain readable at all times as plain status outputs.

Top module: `tagged_arith_unit`

## Requirements
- R1: After reset, `res_valid`, `trap_tag` and all four flags are 0, and `res_data` is 0.
- R2: If bit 0 or bit 1 of either operand is set on an accepted operation, `trap_tag` is 1 in the cycle after acceptance and `res_valid` is 0.
- R3: An addition (`op_sub`=0) whose signed result does not fit in 32 bits traps. The overflow test is bit 31 of NOT(a XOR b) AND (a XOR sum).
- R4: A subtraction (`op_sub`=1) whose signed result does not fit in 32 bits traps. The overflow test is bit 31 of (a XOR b) AND (a XOR difference).
- R5: A trapping operation leaves all four flags and `res_data` unchanged.
- R6: A non-trapping operation gives `res_valid`=1 in the next cycle. At that point `res_data` equals a+b or a-b modulo 2^32.
- R7: For a successful addition, carry is 1 exactly when the unsigned sum is less than a.
- R8: For a successful subtraction, carry is 1 exactly when a is unsigned-less than b.
- R9: After a successful operation, negative equals result bit 31, zero is 1 exactly when the result is 0, and overflow is 0.
- R10: A cycle with `op_valid`=0 produces no pulse on the next cycle and changes neither the flags nor `res_data`.
- R11: `res_valid` and `trap_tag` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, accepted every cycle it is high |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| opnd_a | input | 32 | First operand (minuend for subtract) |
| opnd_b | input | 32 | Second operand |
| res_valid | output | 1 | One-cycle pulse: result committed |
| res_data | output | 32 | Last committed result |
| trap_tag | output | 1 | One-cycle tag-overflow trap request |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |

## Verification
A wrong flag or result register is visible at the ports immediately, because the flags are continuous outputs and are compared on every clock. Such an error appears in the cycle after the faulty commit. A flag that was wrongly written on a trap, or skipped on a success, persists until the next successful operation, so the comparison keeps failing on each cycle in between. A wrong trap decision appears as a wrong pulse one cycle after the strobe.

// File: rtl/tagsub_pkg.sv
package tagsub_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/tagsub_tag_chk.sv
module tagsub_tag_chk #(
  parameter int WIDTH    = 32,
  parameter int TAG_BITS = 2
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             tag_bad
);
  always_comb tag_bad = |(a[TAG_BITS-1:0] | b[TAG_BITS-1:0]);
endmodule

// File: rtl/tagsub_alu.sv
module tagsub_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);
  logic [WIDTH-1:0] ovf_vec;

  always_comb begin
    if (sub) begin
      res     = a - b;
      carry   = (a < b);
      ovf_vec = (a ^ b) & (a ^ res);
    end else begin
      res     = a + b;
      carry   = (res < a);
      ovf_vec = ~(a ^ b) & (a ^ res);
    end
    ovf = ovf_vec[WIDTH-1];
  end
endmodule

// File: rtl/tagsub_flag_reg.sv
module tagsub_flag_reg
  import tagsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [WIDTH-1:0] res,
  input  logic             carry,
  output cc_t              cc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc <= '0;
    end else if (commit) begin
      cc.n <= res[WIDTH-1];
      cc.z <= (res == '0);
      cc.v <= 1'b0;
      cc.c <= carry;
    end
  end

  AST_V_CLEAR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !cc.v); // R9
endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
  import tagsub_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int TAG_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             trap_tag,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  logic             tag_bad;
  logic [WIDTH-1:0] alu_res;
  logic             alu_carry;
  logic             alu_ovf;
  logic             trap_now;
  logic             commit;
  cc_t              cc;

  tagsub_tag_chk #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_tag (
    .a(opnd_a), .b(opnd_b), .tag_bad(tag_bad)
  );

  tagsub_alu #(.WIDTH(WIDTH)) u_alu (
    .a(opnd_a), .b(opnd_b), .sub(op_sub),
    .res(alu_res), .carry(alu_carry), .ovf(alu_ovf)
  );

  always_comb begin
    trap_now = op_valid & (tag_bad | alu_ovf);
    commit   = op_valid & ~trap_now;
  end

  tagsub_flag_reg #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .res(alu_res), .carry(alu_carry), .cc(cc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      trap_tag  <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= commit;
      trap_tag  <= trap_now;
      if (commit) res_data <= alu_res;
    end
  end

  always_comb begin
    flag_n = cc.n;
    flag_z = cc.z;
    flag_v = cc.v;
    flag_c = cc.c;
  end

  AST_TAG_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && |(opnd_a[TAG_BITS-1:0] | opnd_b[TAG_BITS-1:0])) |=> (trap_tag && !res_valid)); // R2
  AST_HOLD_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_tag |-> ($stable(cc) && $stable(res_data))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !trap_tag)); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && trap_tag)); // R11
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_z == (res_data == '0))); // R9
endmodule

// File: tb/tagged_arith_unit_tb.sv
module tagged_arith_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        res_valid, trap_tag, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] res_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  // reference state
  logic        m_n = 0, m_z = 0, m_v = 0, m_c = 0;
  logic [31:0] m_data = '0;
  logic        m_valid = 0, m_trap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_arith_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .res_data(res_data), .trap_tag(trap_tag), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(res_valid == m_valid, req, "res_valid", res_valid, m_valid);
    chk(trap_tag  == m_trap,  req, "trap_tag",  trap_tag,  m_trap);
    chk(res_data  == m_data,  req, "res_data",  res_data,  m_data);
    chk({flag_n, flag_z, flag_v, flag_c} == {m_n, m_z, m_v, m_c}, req, "flags nzvc",
        {flag_n, flag_z, flag_v, flag_c}, {m_n, m_z, m_v, m_c});
  endtask

  // Behavioural model: signed range test via wide integers.
  task automatic model(input bit v, input bit s, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sres;
    logic [32:0] u;
    logic [31:0] r;
    bit bad;
    m_valid = 0;
    m_trap  = 0;
    if (!v) return;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sres = s ? sa - sb : sa + sb;
    bad = (a[1:0] != 0) || (b[1:0] != 0) ||
          (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
    if (bad) begin
      m_trap = 1;
      return;
    end
    u = s ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    r = u[31:0];
    m_valid = 1;
    m_data  = r;
    m_n = r[31];
    m_z = (r == 0);
    m_v = 0;
    m_c = u[32];
  endtask

  task automatic step(input bit v, input bit s, input logic [31:0] a,
                      input logic [31:0] b, input string req);
    op_valid = v; op_sub = s; opnd_a = a; opnd_b = b;
    @(posedge clk);
    model(v, s, a, b);
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");            // reset state
    rst_n = 1;
    step(0, 0, 32'h0, 32'h0, "R1");
    step(1, 0, 32'h0000_0010, 32'h0000_0020, "R6");   // plain add
    step(1, 1, 32'h0000_0100, 32'h0000_0040, "R6");   // plain sub
    step(1, 0, 32'h0000_0011, 32'h0000_0020, "R2");   // tag on a
    step(1, 1, 32'h0000_0100, 32'h0000_0002, "R2");   // tag on b
    step(1, 0, 32'h7FFF_FFFC, 32'h0000_0004, "R3");   // add overflow
    step(1, 0, 32'h8000_0000, 32'h8000_0000, "R3");   // negative add overflow
    step(1, 1, 32'h8000_0000, 32'h0000_0004, "R4");   // sub overflow
    step(1, 1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, "R4");   // sub overflow other sign
    step(1, 0, 32'hFFFF_FFFC, 32'h0000_0008, "R7");   // carry, no ovf
    step(1, 0, 32'hFFFF_FFFC, 32'h0000_0004, "R9");   // zero with carry
    step(1, 0, 32'h8000_0004, 32'h0000_0000, "R5");   // N set baseline
    step(1, 0, 32'h0000_0003, 32'h0000_0000, "R5");   // trap keeps flags
    step(1, 1, 32'h0000_0004, 32'h0000_0008, "R8");   // borrow, negative
    step(1, 1, 32'h0000_0008, 32'h0000_0008, "R9");   // zero, no borrow
    step(0, 0, 32'h1234_5678, 32'h0000_0004, "R10");  // idle
    step(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (($urandom % 4) != 0) begin ra[1:0] = 0; rb[1:0] = 0; end
      step(($urandom % 5) != 0, $urandom % 2, ra, rb, "R11");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule